// File: doc/BRIEF.md
# GPIO Set/Clear Control Word

This block holds the control state for a four-pin general-purpose I/O port. Software reaches it through a 32-bit configuration word. It has an address-hit qualifier, a write strobe, four byte enables, write data and a combinational read path. The output value register and the output enable register are never loaded directly. Each one changes only through a pair of fields: one in which every 1 sets the matching pin bit, and one in which every 1 clears it. A bit written as 0 leaves that pin alone. Several software agents can therefore change single pins without a read-modify-write sequence.

The registered output values and active-high enables feed external tri-state pads. The pad levels come back on `pin_in`. A two-stage synchronizer brings them into the register clock domain, and they read back in the top nibble of the same word. Byte 0 belongs to other logic and reads as zero here. Bits 27:24 are reserved.

Top module: `gpio_sc_regs`

## Requirements
- R1: A write with `cfg_be[1]` high and bit 8+i of `cfg_wdata` set clears the output value of pin i.
- R2: A write with `cfg_be[1]` high and bit 12+i set sets the output value of pin i, unless R5's clear rule applies.
- R3: A write with `cfg_be[2]` high and bit 16+i set clears the enable of pin i, so `pin_oe[i]` goes to 0.
- R4: A write with `cfg_be[2]` high and bit 20+i set sets the enable of pin i, so `pin_oe[i]` goes to 1.
- R5: A set or clear bit written as 0 changes nothing. When the set and clear bits of one pin are both 1 in the same write, the result is 0.
- R6: A read returns the output values in both bits 11:8 and bits 15:12. It returns the enables in both bits 19:16 and bits 23:20.
- R7: `pin_out[i]` is 0 whenever `pin_oe[i]` is 0. Otherwise it equals the stored output value.
- R8: A write sampled at a rising edge shows on `pin_out`/`pin_oe` directly after that edge. The outputs hold the old value before that edge.
- R9: `cfg_rdata[31:28]` shows a level of `pin_in` two rising edges after it was sampled. After one edge the old level still shows.
- R10: Bits 27:24 and 7:0 of `cfg_rdata` always read 0. Writes to byte 3 or byte 0 change no state.
- R11: A byte whose enable is low is not written. Byte 1 holds the output value fields and byte 2 holds the enable fields, and each is gated on its own.
- R12: Synchronous active-high `rst` clears the output values, the enables and the synchronizer to 0.
- R13: A write needs both `cfg_hit` and `cfg_wr` high. `cfg_rdata` is 0 while `cfg_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_hit | input | 1 | Access targets this word |
| cfg_wr | input | 1 | Write strobe for the access |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational, 0 when not hit |
| pin_in | input | 4 | Pad levels, asynchronous |
| pin_out | output | 4 | Output value to the pads |
| pin_oe | output | 4 | Output driver enable, active high |

## Verification
A corrupted output value or enable bit shows in two places. It appears on `pin_out`/`pin_oe` straight after the faulty edge, and it appears in both copies of its field on the next read. The bench therefore compares the pins and the full read word against a bench-side model before every clock edge. A fault in the synchronizer or the reserved lanes shows on the next read with `cfg_hit` high. Random byte enables, random set/clear overlap and random pin levels run alongside directed cases for clear priority, reserved bytes and latency.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    localparam int NPIN   = 4;
    localparam int WORD_W = 32;

    // Field positions inside the control word; the read layout depends on them.
    localparam int OD_CLR_LSB = 8;
    localparam int OD_SET_LSB = 12;
    localparam int OE_CLR_LSB = 16;
    localparam int OE_SET_LSB = 20;
    localparam int RSVD_LSB   = 24;
    localparam int LVL_LSB    = 28;

    // Byte lane holding each pair of fields.
    localparam int OD_LANE = OD_CLR_LSB / 8;
    localparam int OE_LANE = OE_CLR_LSB / 8;

    typedef logic [NPIN-1:0] pinvec_t;

    typedef struct packed {
        pinvec_t set;
        pinvec_t clr;
    } setclr_t;

    typedef struct packed {
        setclr_t od;
        setclr_t oe;
    } wreq_t;

    // Clear wins over set for the same pin.
    function automatic pinvec_t apply_setclr(pinvec_t cur, setclr_t r);
        return (cur | r.set) & ~r.clr;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(pinvec_t lvl, pinvec_t oe, pinvec_t od);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LVL_LSB    +: NPIN] = lvl;
        w[OE_SET_LSB +: NPIN] = oe;
        w[OE_CLR_LSB +: NPIN] = oe;
        w[OD_SET_LSB +: NPIN] = od;
        w[OD_CLR_LSB +: NPIN] = od;
        return w;
    endfunction

endpackage

// File: rtl/gpio_sc_wdec.sv
module gpio_sc_wdec
    import gpio_sc_pkg::*;
(
    input  logic                cfg_hit,
    input  logic                cfg_wr,
    input  logic [WORD_W/8-1:0] cfg_be,
    input  logic [WORD_W-1:0]   cfg_wdata,
    output wreq_t               req
);
    logic wr_go;
    logic od_en;
    logic oe_en;

    assign wr_go = cfg_hit & cfg_wr;
    assign od_en = wr_go & cfg_be[OD_LANE];
    assign oe_en = wr_go & cfg_be[OE_LANE];

    always_comb begin
        req        = '0;
        req.od.set = od_en ? cfg_wdata[OD_SET_LSB +: NPIN] : '0;
        req.od.clr = od_en ? cfg_wdata[OD_CLR_LSB +: NPIN] : '0;
        req.oe.set = oe_en ? cfg_wdata[OE_SET_LSB +: NPIN] : '0;
        req.oe.clr = oe_en ? cfg_wdata[OE_CLR_LSB +: NPIN] : '0;
    end

    // Lanes 0 and 3 carry nothing writable in this block.
    logic unused_lanes;
    assign unused_lanes = ^{cfg_be[0], cfg_be[3], cfg_wdata[31:24], cfg_wdata[7:0]};

endmodule

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank
    import gpio_sc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  setclr_t upd,
    output pinvec_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= apply_setclr(q, upd);
    end
endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_sc_regs.sv
module gpio_sc_regs
    import gpio_sc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_hit,
    input  logic        cfg_wr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [3:0]  pin_in,
    output logic [3:0]  pin_out,
    output logic [3:0]  pin_oe
);
    wreq_t   req;
    pinvec_t od_q;
    pinvec_t oe_q;
    pinvec_t lvl_q;

    gpio_sc_wdec u_wdec (
        .cfg_hit   (cfg_hit),
        .cfg_wr    (cfg_wr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .req       (req)
    );

    gpio_sc_bank u_od (.clk(clk), .rst(rst), .upd(req.od), .q(od_q));
    gpio_sc_bank u_oe (.clk(clk), .rst(rst), .upd(req.oe), .q(oe_q));

    gpio_sc_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl_q)
    );

    assign pin_oe    = oe_q;
    assign pin_out   = od_q & oe_q;
    assign cfg_rdata = cfg_hit ? pack_word(lvl_q, oe_q, od_q) : '0;

endmodule

// File: rtl/gpio_sc_regs_chk.sv
module gpio_sc_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_hit,
    input logic        cfg_wr,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic [3:0]  pin_in,
    input logic [3:0]  pin_oe,
    input logic [3:0]  od_q,
    input logic [3:0]  oe_q
);
    logic       wr_od;
    logic       wr_oe;
    logic [1:0] live;
    assign wr_od = cfg_hit && cfg_wr && cfg_be[1];
    assign wr_oe = cfg_hit && cfg_wr && cfg_be[2];

    always_ff @(posedge clk) begin
        if (rst)            live <= '0;
        else if (live != 3) live <= live + 2'd1;
    end

    // R1
    od_clr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_od |=> ((od_q & $past(cfg_wdata[11:8])) == 4'h0));
    // R2
    od_set_chk: assert property (@(posedge clk) disable iff (rst)
        wr_od |=> ((od_q & ($past(cfg_wdata[15:12]) & ~$past(cfg_wdata[11:8])))
                  == ($past(cfg_wdata[15:12]) & ~$past(cfg_wdata[11:8]))));
    // R3
    oe_clr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_oe |=> ((pin_oe & $past(cfg_wdata[19:16])) == 4'h0));
    // R4
    oe_set_chk: assert property (@(posedge clk) disable iff (rst)
        wr_oe |=> ((pin_oe & ($past(cfg_wdata[23:20]) & ~$past(cfg_wdata[19:16])))
                  == ($past(cfg_wdata[23:20]) & ~$past(cfg_wdata[19:16]))));
    // R11
    od_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_od |=> $stable(od_q));
    // R11
    oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_oe |=> $stable(oe_q));
    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[27:24] == 4'h0) && (cfg_rdata[7:0] == 8'h0));
    // R13
    nohit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_hit |-> (cfg_rdata == 32'h0));
    // R9
    lvl_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (live == 3 && cfg_hit) |-> (cfg_rdata[31:28] == $past(pin_in, 2)));
    // R12
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (od_q == 4'h0 && oe_q == 4'h0));
endmodule

bind gpio_sc_regs gpio_sc_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_hit   (cfg_hit),
    .cfg_wr    (cfg_wr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .od_q      (od_q),
    .oe_q      (oe_q)
);

// File: tb/sim_gpio_sc_regs.sv
module sim_gpio_sc_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_hit = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic [3:0]  pin_in = 4'h0;
    logic [3:0]  pin_out;
    logic [3:0]  pin_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [3:0] od_m = 4'h0, oe_m = 4'h0, s1_m = 4'h0, s2_m = 4'h0;

    always #2 clk = ~clk;

    gpio_sc_regs u0 (
        .clk(clk), .rst(rst), .cfg_hit(cfg_hit), .cfg_wr(cfg_wr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [3:0] nxt(logic [3:0] cur, logic [3:0] s, logic [3:0] c);
        return (cur | s) & ~c;
    endfunction

    function automatic logic [31:0] exp_rd(bit hit);
        if (!hit) return 32'h0;
        return {s2_m, 4'h0, oe_m, oe_m, od_m, od_m, 8'h00};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle; check the present outputs, then advance the model at the edge.
    task automatic step(string tag, bit hit, bit wr, logic [3:0] be, logic [31:0] wd, logic [3:0] pin);
        @(negedge clk);
        cfg_hit = hit; cfg_wr = wr; cfg_be = be; cfg_wdata = wd; pin_in = pin;
        #1;
        chk(tag, "rdata",   cfg_rdata, exp_rd(hit));
        chk(tag, "pin_out", {28'h0, pin_out}, {28'h0, od_m & oe_m});
        chk(tag, "pin_oe",  {28'h0, pin_oe},  {28'h0, oe_m});
        @(posedge clk);
        if (hit && wr) begin
            if (be[1]) od_m = nxt(od_m, wd[15:12], wd[11:8]);
            if (be[2]) oe_m = nxt(oe_m, wd[23:20], wd[19:16]);
        end
        s2_m = s1_m;
        s1_m = pin;
    endtask

    task automatic rd(string tag, logic [3:0] pin);
        step(tag, 1'b1, 1'b0, 4'h0, 32'h0, pin);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        rd("R12", 4'h0);                                         // reset state
        step("R4",  1, 1, 4'h4, 32'h00F0_0000, 4'h0);            // enable all
        step("R2",  1, 1, 4'h2, 32'h0000_5000, 4'h0);            // set pins 0,2
        rd("R8", 4'h0);                                          // new value after edge
        rd("R6", 4'h0);
        step("R1",  1, 1, 4'h2, 32'h0000_0100, 4'h0);            // clear pin 0
        rd("R1", 4'h0);
        step("R5",  1, 1, 4'h2, 32'h0000_0000, 4'h0);            // zero write
        rd("R5", 4'h0);
        step("R5",  1, 1, 4'h2, 32'h0000_FA00, 4'h0);            // overlap: clear wins
        rd("R5", 4'h0);
        step("R3",  1, 1, 4'h4, 32'h0003_0000, 4'h0);            // disable pins 0,1
        rd("R7", 4'h0);                                          // undriven pins read 0 on pin_out
        step("R11", 1, 1, 4'hB, 32'hFFFF_FFFF, 4'h0);            // byte 2 masked
        rd("R11", 4'h0);
        step("R11", 1, 1, 4'h4, 32'hFF00_FF00, 4'h0);            // byte 1 masked
        rd("R11", 4'h0);
        step("R10", 1, 1, 4'h9, 32'hFFFF_FFFF, 4'h0);            // bytes 3,0 only
        rd("R10", 4'h0);
        step("R13", 0, 1, 4'hF, 32'h00FF_FF00, 4'h0);            // no hit
        step("R13", 1, 0, 4'hF, 32'h00FF_FF00, 4'h0);            // no write strobe
        rd("R13", 4'h0);
        rd("R9", 4'hA);                                          // level A sampled
        rd("R9", 4'hA);                                          // one edge: old level
        rd("R9", 4'h5);                                          // two edges: A
        rd("R9", 4'h5);
        rd("R9", 4'h5);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step("R6", r[0] | r[1], r[2] | r[3], r[7:4], $urandom, r[11:8]);
        end

        step("R12", 1, 1, 4'h6, 32'h00FF_FF00, 4'h3);
        @(negedge clk); rst = 1'b1;
        @(posedge clk);
        od_m = 4'h0; oe_m = 4'h0; s1_m = 4'h0; s2_m = 4'h0;
        @(negedge clk); rst = 1'b0;
        rd("R12", 4'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule